// File: doc/BRIEF.md
# Dual-Timeout Supervisory Watchdog

This block supervises a processor by watching a single service line and pulling an active-low reset output when the line stops moving. Either a rising or a falling change of the service line counts as a kick. Time is measured in ticks supplied by a one-cycle `tick_en` strobe (nominally one per millisecond), so every period is a count of strobes rather than of clock cycles.

Two timeout lengths exist. Each reset pulse, whether issued by the block itself, by its synchronous reset or by a supply recovery, arms the long grace timeout. The first kick seen after reset ends switches the block to the short timeout for the rest of the run. A low `wd_enable` stands for a floating service pin and stops the watchdog. A low `supply_ok` holds reset asserted until the supply returns, after which one full reset pulse is issued.

Top module: `wdog_supervisor`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `rst_out_n` is 0 and `long_armed` is 1.
- R2: A reset pulse lasts exactly RESET_TICKS ticks; with a tick every cycle, `rst_out_n` stays 0 for RESET_TICKS cycles after `rst` is released.
- R3: Without kicks, `rst_out_n` stays 1 for exactly LONG_TICKS ticks after a reset pulse ends, then falls.
- R4: The first change of `wdi` seen while reset is released and the watchdog is enabled clears `long_armed` to 0 (short timeout armed); a falling change works as well as a rising one.
- R5: Changes of `wdi` in either direction restart the timeout, so changes spaced closer than the armed timeout keep `rst_out_n` at 1 indefinitely.
- R6: In short mode, `rst_out_n` falls SHORT_TICKS ticks after the last kick is taken; a kick is taken two cycles after `wdi` changes (two-flop synchronizer plus edge register), so with a tick every cycle the output stays 1 for SHORT_TICKS+2 cycles after the `wdi` change.
- R7: Every reset pulse the block issues on its own re-arms the long timeout: `long_armed` is 1 from the cycle `rst_out_n` falls.
- R8: While `wd_enable` is 0 no reset is issued, `wdi` changes do not clear `long_armed`, and the timeout count is held at zero; after re-enabling, the full armed timeout elapses before reset.
- R9: While `supply_ok` is 0, `rst_out_n` is 0 from the next cycle on and `long_armed` is 1; when it returns to 1, a full RESET_TICKS pulse follows, then the long timeout.
- R10: `wdi` changes that occur during a reset pulse are ignored: the long timeout stays armed after the pulse.
- R11: Cycles with `tick_en` at 0 advance no counter: `rst_out_n` does not change on them while `supply_ok` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle time-base strobe; counters advance only when high |
| wdi | input | 1 | Asynchronous service line; each change is a kick |
| wd_enable | input | 1 | 1 = watchdog active, 0 = service pin considered floating |
| supply_ok | input | 1 | 1 = supply above reset threshold |
| rst_out_n | output | 1 | Active-low supervisory reset |
| long_armed | output | 1 | 1 = long timeout armed, 0 = short timeout armed |

## Verification
A wrong control state shows up at `rst_out_n` within one cycle, since that output is decoded straight from the state register; a wrong mode flag shows on `long_armed` at once and, later, as a high period of the wrong length. A counter that clears or advances wrongly is only visible at the end of a period, as a pulse or timeout that is one or more ticks off, so the bench measures every high and low period exactly in cycles with a tick on each cycle. A lost or doubled kick shows as a missing mode change or a reset where none was due, at most one timeout later.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        WD_HOLD  = 2'd0,
        WD_PULSE = 2'd1,
        WD_WATCH = 2'd2
    } wd_state_e;

    typedef struct packed {
        logic clear;
        logic advance;
    } cnt_cmd_s;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int unsigned count_bits(input int unsigned a, input int unsigned b,
                                               input int unsigned c);
        return $clog2(max3(a, b, c) + 1);
    endfunction

endpackage

// File: rtl/wdog_svc_sync.sv
module wdog_svc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wdi,
    output logic kick
);
    logic [STAGES-1:0] pipe;
    logic              last;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[0] <= 1'b0;
                else     pipe[0] <= wdi;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= 1'b0;
                else     pipe[g] <= pipe[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last <= 1'b0;
        else     last <= pipe[STAGES-1];
    end

    assign kick = pipe[STAGES-1] ^ last;
endmodule

// File: rtl/wdog_tick_cnt.sv
module wdog_tick_cnt #(
    parameter int unsigned W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  wdog_pkg::cnt_cmd_s  cmd,
    output logic [W-1:0]        count
);
    always_ff @(posedge clk) begin
        if (rst || cmd.clear) count <= '0;
        else if (cmd.advance) count <= count + 1'b1;
    end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
#(
    parameter int unsigned W           = 11,
    parameter int unsigned RESET_TICKS = 140,
    parameter int unsigned LONG_TICKS  = 1000,
    parameter int unsigned SHORT_TICKS = 70
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_en,
    input  logic         wd_enable,
    input  logic         supply_ok,
    input  logic         kick,
    input  logic [W-1:0] count,
    output cnt_cmd_s     cmd,
    output wd_state_e    state,
    output logic         long_mode
);
    localparam logic [W-1:0] PULSE_LAST = W'(RESET_TICKS - 1);
    localparam logic [W-1:0] LONG_LAST  = W'(LONG_TICKS - 1);
    localparam logic [W-1:0] SHORT_LAST = W'(SHORT_TICKS - 1);

    wd_state_e    state_d;
    logic         long_d;
    logic [W-1:0] limit;

    assign limit = long_mode ? LONG_LAST : SHORT_LAST;

    always_comb begin
        state_d     = state;
        long_d      = long_mode;
        cmd.clear   = 1'b0;
        cmd.advance = 1'b0;
        if (!supply_ok) begin
            state_d   = WD_HOLD;
            long_d    = 1'b1;
            cmd.clear = 1'b1;
        end else begin
            case (state)
                WD_HOLD: begin
                    state_d   = WD_PULSE;
                    long_d    = 1'b1;
                    cmd.clear = 1'b1;
                end
                WD_PULSE: begin
                    long_d = 1'b1;
                    if (tick_en) begin
                        if (count == PULSE_LAST) begin
                            state_d   = WD_WATCH;
                            cmd.clear = 1'b1;
                        end else begin
                            cmd.advance = 1'b1;
                        end
                    end
                end
                WD_WATCH: begin
                    if (!wd_enable) begin
                        cmd.clear = 1'b1;
                    end else if (kick) begin
                        cmd.clear = 1'b1;
                        long_d    = 1'b0;
                    end else if (tick_en) begin
                        if (count == limit) begin
                            state_d   = WD_PULSE;
                            long_d    = 1'b1;
                            cmd.clear = 1'b1;
                        end else begin
                            cmd.advance = 1'b1;
                        end
                    end
                end
                default: begin
                    state_d   = WD_HOLD;
                    cmd.clear = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= WD_PULSE;
            long_mode <= 1'b1;
        end else begin
            state     <= state_d;
            long_mode <= long_d;
        end
    end
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
    import wdog_pkg::*;
#(
    parameter int unsigned RESET_TICKS = 140,
    parameter int unsigned LONG_TICKS  = 1000,
    parameter int unsigned SHORT_TICKS = 70,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic wdi,
    input  logic wd_enable,
    input  logic supply_ok,
    output logic rst_out_n,
    output logic long_armed
);
    localparam int unsigned CW = count_bits(RESET_TICKS, LONG_TICKS, SHORT_TICKS);

    logic          kick;
    cnt_cmd_s      cmd;
    logic [CW-1:0] count;
    wd_state_e     state;
    logic          long_mode;

    wdog_svc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .wdi  (wdi),
        .kick (kick)
    );

    wdog_tick_cnt #(.W(CW)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .count (count)
    );

    wdog_ctrl #(
        .W           (CW),
        .RESET_TICKS (RESET_TICKS),
        .LONG_TICKS  (LONG_TICKS),
        .SHORT_TICKS (SHORT_TICKS)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .wd_enable (wd_enable),
        .supply_ok (supply_ok),
        .kick      (kick),
        .count     (count),
        .cmd       (cmd),
        .state     (state),
        .long_mode (long_mode)
    );

    assign rst_out_n  = (state == WD_WATCH);
    assign long_armed = long_mode;
endmodule

// File: rtl/wdog_supervisor_props.sv
module wdog_supervisor_props (
    input logic clk,
    input logic rst,
    input logic tick_en,
    input logic wd_enable,
    input logic supply_ok,
    input logic rst_out_n,
    input logic long_armed
);
    // R1: synchronous reset starts a reset pulse with the long timeout armed
    assert_reset_entry_R1: assert property (@(posedge clk)
        rst |=> (!rst_out_n && long_armed));

    // R7: a reset pulse always comes with the long timeout armed
    assert_long_rearm_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_out_n) |-> long_armed);

    // R4: switching to short mode only happens while the output is released
    assert_short_when_running_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(long_armed) |-> (rst_out_n && $past(rst_out_n)));

    // R9: low supply forces reset on the next cycle
    assert_supply_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> (!rst_out_n && long_armed));

    // R8: disabled watchdog never issues a reset
    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (rst_out_n && !wd_enable && supply_ok) |=> rst_out_n);

    // R11: no tick, no output change while supply is good
    assert_tick_gates_R11: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && supply_ok) |=> $stable(rst_out_n));

    // R2: release from a pulse happens only on a tick
    assert_release_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_out_n) |-> $past(tick_en));
endmodule

bind wdog_supervisor wdog_supervisor_props u_props (.*);

// File: tb/wdog_supervisor_test.sv
module wdog_supervisor_test;
    localparam int RT = 4;
    localparam int LT = 12;
    localparam int ST = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en = 1'b1;
    logic wdi = 1'b0;
    logic wd_enable = 1'b1;
    logic supply_ok = 1'b1;
    logic rst_out_n;
    logic long_armed;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    wdog_supervisor #(
        .RESET_TICKS (RT),
        .LONG_TICKS  (LT),
        .SHORT_TICKS (ST)
    ) uut (
        .clk        (clk),
        .rst        (rst),
        .tick_en    (tick_en),
        .wdi        (wdi),
        .wd_enable  (wd_enable),
        .supply_ok  (supply_ok),
        .rst_out_n  (rst_out_n),
        .long_armed (long_armed)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // count samples (current one included) while rst_out_n equals lvl
    task automatic run_length(input logic lvl, output int n);
        n = 0;
        while (rst_out_n == lvl) begin
            n++;
            @(negedge clk);
        end
    endtask

    // count the following samples until rst_out_n differs from lvl
    task automatic run_after(input logic lvl, output int n);
        n = 0;
        forever begin
            @(negedge clk);
            if (rst_out_n != lvl) break;
            n++;
        end
    endtask

    task automatic t_reset_and_free_run();
        int n;
        repeat (3) @(negedge clk);
        check(rst_out_n == 1'b0 && long_armed == 1'b1, "R1 reset state",
              {rst_out_n, long_armed}, 2'b01);
        rst = 1'b0;
        run_length(1'b0, n);
        check(n == RT, "R2 pulse length", n, RT);
        check(long_armed == 1'b1, "R3 long armed after pulse", long_armed, 1);
        run_length(1'b1, n);
        check(n == LT, "R3 long timeout", n, LT);
        check(long_armed == 1'b1, "R7 long armed in self pulse", long_armed, 1);
        run_length(1'b0, n);
        check(n == RT, "R2 repeat pulse length", n, RT);
        run_length(1'b1, n);
        check(n == LT, "R7 long timeout rearmed", n, LT);
    endtask

    task automatic t_kicks();
        int n;
        wdi = ~wdi;  // during pulse: must be ignored
        run_length(1'b0, n);
        check(n == RT, "R10 pulse length with kick", n, RT);
        check(long_armed == 1'b1, "R10 kick in pulse ignored", long_armed, 1);
        wdi = 1'b0;  // falling change
        repeat (3) @(negedge clk);
        check(long_armed == 1'b0, "R4 falling kick arms short", long_armed, 0);
        for (int i = 0; i < 12; i++) begin
            wdi = ~wdi;
            repeat (3) begin
                @(negedge clk);
                check(rst_out_n == 1'b1, "R5 kicks hold reset off", rst_out_n, 1);
            end
        end
        wdi = ~wdi;
        run_after(1'b1, n);
        check(n == ST + 2, "R6 short timeout", n, ST + 2);
        check(long_armed == 1'b1, "R7 long rearmed after short", long_armed, 1);
        run_length(1'b0, n);
        check(n == RT, "R2 pulse after short", n, RT);
    endtask

    task automatic t_tick_gate();
        int n;
        tick_en = 1'b0;
        repeat (40) @(negedge clk);
        check(rst_out_n == 1'b1, "R11 no tick no timeout", rst_out_n, 1);
        tick_en = 1'b1;
        run_length(1'b1, n);
        check(n == LT, "R11 timeout resumes", n, LT);
        tick_en = 1'b0;
        repeat (30) @(negedge clk);
        check(rst_out_n == 1'b0, "R11 pulse frozen", rst_out_n, 0);
        tick_en = 1'b1;
        run_length(1'b0, n);
        check(n == RT, "R11 pulse resumes", n, RT);
    endtask

    task automatic t_disable();
        int n;
        wd_enable = 1'b0;
        @(negedge clk);
        wdi = ~wdi;
        repeat (3 * LT) @(negedge clk);
        check(rst_out_n == 1'b1, "R8 disabled no reset", rst_out_n, 1);
        check(long_armed == 1'b1, "R8 kick while disabled ignored", long_armed, 1);
        wd_enable = 1'b1;
        run_after(1'b1, n);
        check(n == LT - 1, "R8 full timeout after enable", n, LT - 1);
        run_length(1'b0, n);
        check(n == RT, "R2 pulse after enable", n, RT);
    endtask

    task automatic t_supply();
        int n;
        wdi = ~wdi;
        repeat (4) @(negedge clk);
        check(long_armed == 1'b0, "R4 short before supply drop", long_armed, 0);
        supply_ok = 1'b0;
        @(negedge clk);
        check(rst_out_n == 1'b0 && long_armed == 1'b1, "R9 supply low asserts",
              {rst_out_n, long_armed}, 2'b01);
        repeat (30) @(negedge clk);
        check(rst_out_n == 1'b0, "R9 held while supply low", rst_out_n, 0);
        supply_ok = 1'b1;
        run_after(1'b0, n);
        check(n == RT, "R9 full pulse on recovery", n, RT);
        run_length(1'b1, n);
        check(n == LT, "R9 long timeout after recovery", n, LT);
    endtask

    initial begin
        t_reset_and_free_run();
        t_kicks();
        t_tick_gate();
        t_disable();
        t_supply();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                checks++;
                errors++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end
endmodule